// File: doc/BRIEF.md
# Dual I/O Read Shifter

This block is the read datapath of a serial flash for its two dual-output read commands. It takes over once an external decoder has recognised the opcode. It then collects a 24-bit start address and counts out the dummy clocks. After that it streams array bytes two bits per clock on both I/O lines. In the single-address mode the address arrives one bit per clock on line 0 and eight dummy clocks follow. In the dual-address mode the address arrives two bits per clock and four dummy clocks follow.

Bytes come from a simple synchronous read port. The port registers its output on the rising edge where the read strobe is high and holds that value otherwise. The block issues the read for the next byte on the same rising edge that completes the current byte, so the output stream has no gaps. The address rolls over at the top of the array. Chip select high resets the block asynchronously and releases both lines at once.

Top module: `dual_read_shifter`

## Requirements
- R1: With `dual_addr` low when `start` is sampled, the 24 address bits are taken from `sio_in[0]`, MSB first, on the 24 rising edges after the start edge. `sio_in[1]` is ignored. Eight dummy rising edges follow.
- R2: With `dual_addr` high, the address is taken over 12 rising edges. Each edge takes two bits: `sio_in[1]` carries the higher bit of the pair (A23, A21, …) and `sio_in[0]` the lower (A22, A20, …). Four dummy rising edges follow.
- R3: In dual-address mode, the value on `sio_in` at the second dummy edge must equal the value at the first dummy edge. If it differs, the read is abandoned: no memory read is issued and `sio_oe` stays 00 until `cs_n` rises.
- R4: Each byte takes four clocks. `sio_out[1]` carries bits 7, 5, 3, 1 and `sio_out[0]` carries bits 6, 4, 2, 0, in that order.
- R5: Output pairs change only on falling `sclk` edges. The first pair appears on the falling edge after the last dummy rising edge, and a pair does not change at the rising edge where the host samples it.
- R6: Successive bytes come from successive addresses. Only the low AW bits of the received address select a byte, so the address after 2^AW−1 is 0. The stream continues until `cs_n` rises.
- R7: If `busy` is high when `start` is sampled, the read is rejected: no memory read is issued and `sio_oe` stays 00 until `cs_n` rises.
- R8: `sio_oe` is 00 in reset, while the address is being received and during the dummy clocks. It is 11 while data is output, and it returns to 00 without a clock as soon as `cs_n` goes high.
- R9: Exactly one `mem_rd` pulse is issued per byte, with `mem_addr` holding that byte's address. The first pulse is on the last dummy edge. Each later pulse is on the rising edge that samples the fourth pair of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs are captured on the rising edge, outputs change on the falling edge |
| cs_n | input | 1 | Chip select, active low; high resets the block asynchronously |
| start | input | 1 | Opcode accepted; the address phase begins on the next rising edge |
| dual_addr | input | 1 | Sampled with start: 1 selects the two-bit address phase |
| busy | input | 1 | A program, erase or status write is in progress; sampled with start |
| sio_in | input | 2 | Values seen on the two I/O lines |
| sio_out | output | 2 | Data driven onto the two I/O lines |
| sio_oe | output | 2 | Output enables of the two I/O lines |
| mem_rd | output | 1 | Read strobe to the array port |
| mem_addr | output | AW | Byte address to the array port |
| mem_data | input | 8 | Registered read data from the array port |

## Verification
A miscounted address or dummy phase shifts the whole data stream by one or more clocks. The first data pair after the dummy clocks then shows it, because `sio_oe` rises too early or too late. A corrupted address register or increment shows up as a wrong byte within the first four clocks of the affected byte. A broken rollover shows up on the byte right after the top address. A wrong pair index swaps bits inside a byte at once. A reject path that leaks shows up as enabled outputs on the first falling edge after the dummy phase.

// File: rtl/dual_read_shifter.sv
`timescale 1ns/1ps
module dual_read_shifter #(
  parameter int AW        = 17,
  parameter int ADDR_BITS = 24,
  parameter int SGL_DUMMY = 8,
  parameter int DUO_DUMMY = 4
) (
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          start,
  input  logic          dual_addr,
  input  logic          busy,
  input  logic [1:0]    sio_in,
  output logic [1:0]    sio_out,
  output logic [1:0]    sio_oe,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data
);
  localparam int CW = $clog2(ADDR_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DUMMY, S_DATA, S_REJ} state_t;

  state_t               st;
  logic [CW-1:0]        cnt;
  logic                 dual;
  logic [ADDR_BITS-1:0] addr;
  logic [1:0]           pi;
  logic [1:0]           pick;

  wire a_last   = cnt == (dual ? CW'(ADDR_BITS/2 - 1) : CW'(ADDR_BITS - 1));
  wire d_last   = cnt == (dual ? CW'(DUO_DUMMY - 1) : CW'(SGL_DUMMY - 1));
  wire bad_mode = dual && cnt == CW'(1) && sio_in != pick;
  wire [1:0] pair = 2'(mem_data >> {~pi, 1'b0});

  assign mem_rd   = (st == S_DUMMY && d_last && !bad_mode) || (st == S_DATA && pi == 2'd3);
  assign mem_addr = addr[AW-1:0];

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      dual <= 1'b0;
      addr <= '0;
      pi   <= '0;
      pick <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dual <= dual_addr;
          cnt  <= '0;
          st   <= busy ? S_REJ : S_ADDR;
        end
        S_ADDR: begin
          addr <= dual ? {addr[ADDR_BITS-3:0], sio_in} : {addr[ADDR_BITS-2:0], sio_in[0]};
          if (a_last) begin
            cnt <= '0;
            st  <= S_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DUMMY: begin
          if (cnt == '0) pick <= sio_in;
          if (bad_mode) begin
            st <= S_REJ;
          end else if (d_last) begin
            st   <= S_DATA;
            pi   <= '0;
            addr <= addr + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          pi <= pi + 1'b1;
          if (pi == 2'd3) addr <= addr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sio_oe  <= 2'b00;
      sio_out <= 2'b00;
    end else begin
      sio_oe  <= {2{st == S_DATA}};
      sio_out <= (st == S_DATA) ? pair : 2'b00;
    end
  end
endmodule

// File: rtl/dual_read_shifter_chk.sv
`timescale 1ns/1ps
module dual_read_shifter_chk #(
  parameter int AW = 17
) (
  input logic          sclk,
  input logic          cs_n,
  input logic          start,
  input logic          busy,
  input logic [2:0]    st,
  input logic [1:0]    sio_oe,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr
);
  logic [AW-1:0] prev_addr;
  logic          have_prev;

  assert_oe_paired_R8: assert property (@(posedge sclk) disable iff (cs_n)
    sio_oe == 2'b00 || sio_oe == 2'b11);

  assert_one_read_per_byte_R9: assert property (@(posedge sclk) disable iff (cs_n)
    mem_rd |=> !mem_rd);

  assert_drive_after_fetch_R5: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(sio_oe[0]) |-> $past(mem_rd));

  assert_busy_rejects_R7: assert property (@(posedge sclk) disable iff (cs_n)
    (st == 3'd0 && start && busy) |=> st == 3'd4);

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (mem_rd) begin
      if (have_prev)
        assert_addr_step_R6: assert (mem_addr == AW'(prev_addr + 1'b1))
          else $error("read address did not advance by one");
      prev_addr <= mem_addr;
      have_prev <= 1'b1;
    end
  end
endmodule

bind dual_read_shifter dual_read_shifter_chk #(.AW(AW)) u_chk (
  .sclk(sclk), .cs_n(cs_n), .start(start), .busy(busy), .st(st),
  .sio_oe(sio_oe), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/test_dual_read_shifter.sv
`timescale 1ns/100ps
module test_dual_read_shifter;
  localparam int AW = 17;

  logic          sclk = 1'b0;
  logic          cs_n = 1'b1;
  logic          start = 1'b0;
  logic          dual_addr = 1'b0;
  logic          busy = 1'b0;
  logic [1:0]    sio_in = 2'b00;
  logic [1:0]    sio_out;
  logic [1:0]    sio_oe;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data = 8'h00;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [AW-1:0] first_addr = '0;

  always #2 sclk = ~sclk;

  dual_read_shifter #(.AW(AW)) i_dual_read_shifter (
    .sclk(sclk), .cs_n(cs_n), .start(start), .dual_addr(dual_addr), .busy(busy),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return 8'((a * 7) ^ (a >> 5) ^ 8'h5A);
  endfunction

  always @(posedge sclk) begin
    if (mem_rd) begin
      if (rd_cnt == 0) first_addr = mem_addr;
      rd_cnt = rd_cnt + 1;
      mem_data <= fb(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input bit dual, input bit bsy, input bit bad_dummy,
                         input logic [23:0] a, input int nb, input string tag);
    int na = dual ? 12 : 24;
    int nd = dual ? 4 : 8;
    bit rej = bsy || (dual && bad_dummy);
    string rtag = bsy ? "R7" : "R3";
    logic [7:0] q_byte[$];
    for (int b = 0; b < nb; b++) q_byte.push_back(fb(AW'(a[AW-1:0] + AW'(b))));
    @(negedge sclk); #1;
    cs_n = 1'b0;
    rd_cnt = 0;
    @(negedge sclk); #1;
    chk(sio_oe == 2'b00, "R8", "oe at start", sio_oe, 0);
    start = 1'b1; dual_addr = dual; busy = bsy;
    for (int j = 0; j < na; j++) begin
      @(negedge sclk); #1;
      chk(sio_oe == 2'b00, "R8", "oe in address", sio_oe, 0);
      start = 1'b0; busy = 1'b0; dual_addr = ~dual;
      if (dual) sio_in = {a[23-2*j], a[22-2*j]};
      else      sio_in = {1'b1, a[23-j]};
    end
    for (int j = 0; j < nd; j++) begin
      @(negedge sclk); #1;
      chk(sio_oe == 2'b00, "R8", "oe in dummy", sio_oe, 0);
      if (dual) sio_in = (j == 0) ? (bad_dummy ? 2'b01 : 2'b11) :
                         (j == 1) ? (bad_dummy ? 2'b10 : 2'b11) : 2'b10;
      else      sio_in = 2'(j);
    end
    for (int b = 0; b < nb; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [1:0] ep = 2'(q_byte[b] >> (6 - 2*p));
        @(negedge sclk); #1;
        sio_in = 2'(b + p);
        if (rej) begin
          chk(sio_oe == 2'b00, rtag, "rejected read drives lines", sio_oe, 0);
        end else begin
          chk(sio_oe == 2'b11, tag, "oe during data", sio_oe, 3);
          chk(sio_out == ep, tag, "data pair (R4 order)", sio_out, ep);
          @(posedge sclk); #0.5;
          chk(sio_out == ep && sio_oe == 2'b11, "R5", "pair moved at rising edge", sio_out, ep);
        end
      end
    end
    @(negedge sclk); #1;
    cs_n = 1'b1;
    #0.5;
    chk(sio_oe == 2'b00, "R8", "oe after cs_n high", sio_oe, 0);
    if (rej) begin
      chk(rd_cnt == 0, rtag, "reads on rejected command", rd_cnt, 0);
    end else begin
      chk(rd_cnt == nb + 1, "R9", "read pulse count", rd_cnt, nb + 1);
      chk(first_addr == a[AW-1:0], "R9", "first read address", first_addr, a[AW-1:0]);
    end
    sio_in = 2'b00;
    repeat (3) @(negedge sclk);
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    #1;
    chk(sio_oe == 2'b00, "R8", "reset oe", sio_oe, 0);
    chk(mem_rd == 1'b0, "R8", "reset read strobe", mem_rd, 0);
    do_read(1'b0, 1'b0, 1'b0, 24'h000123, 3, "R1");
    do_read(1'b0, 1'b0, 1'b0, 24'h01A5C3, 2, "R1");
    do_read(1'b1, 1'b0, 1'b0, 24'h00ABCD, 3, "R2");
    do_read(1'b1, 1'b0, 1'b0, 24'h015A96, 2, "R2");
    do_read(1'b1, 1'b0, 1'b0, 24'hFE0010, 2, "R6");
    do_read(1'b0, 1'b0, 1'b0, 24'h01FFFE, 4, "R6");
    do_read(1'b1, 1'b0, 1'b0, 24'h01FFFF, 2, "R6");
    do_read(1'b0, 1'b1, 1'b0, 24'h000040, 2, "R7");
    do_read(1'b1, 1'b1, 1'b0, 24'h000040, 2, "R7");
    do_read(1'b1, 1'b0, 1'b1, 24'h000200, 2, "R3");
    do_read(1'b1, 1'b0, 1'b0, 24'h000200, 2, "R3");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog run did not complete act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule